// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Front End

This block takes one interrupt line from a chip pin and presents it to a parent interrupt controller as one request wire. The pin is brought into the clock domain through a short synchroniser. A two-bit mode field then chooses what counts as a trigger: a low level, a high level, a falling edge or a rising edge. Each trigger sets a sticky pending flag. The request to the parent is raised while that flag is set and the source is unmasked.

Software reaches three 32-bit registers over a simple single-cycle bus: mode control, pending status and mask. A compile-time parameter picks one of three address layouts for these registers, so one design can serve three register maps. Pending is cleared by writing a one to bit 0. In level modes the flag comes back on the next clock while the pin stays active, so a clear only holds once the source has released the line.

Top module: `nmi_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers read 0, irq_out is low and the mode is active-low level.
- R2: Mode 0 (control bits [1:0] = 0) sets pending bit 0 while the synchronised line is low.
- R3: Mode 1 sets pending bit 0 on a high-to-low transition of the synchronised line, and a steady line sets nothing.
- R4: Mode 2 sets pending bit 0 while the synchronised line is high.
- R5: Mode 3 sets pending bit 0 on a low-to-high transition of the synchronised line, and a steady line sets nothing.
- R6: Control bits [31:2] are plain storage that read back exactly as written, and control changes only on a write to its offset.
- R7: Writing 1 to pending bit 0 clears it and writing 0 leaves it unchanged. In a level mode, a clear issued while the line is still active is followed by the flag setting again.
- R8: An edge trigger in the same cycle as a pending clear leaves pending set, so no edge is lost.
- R9: Pending latches whether or not enable bit 0 is set. irq_out is high one cycle after pending bit 0 and enable bit 0 are both 1, and low one cycle after either is 0.
- R10: LAYOUT 0 places control/pending/enable at 0x00/0x04/0x08, LAYOUT 1 at 0x00/0x04/0x34, and LAYOUT 2 places control at 0x00, enable at 0x04 and pending at 0x08.
- R11: A read from any unmapped offset returns 0, and a write to one changes no register.
- R12: A change on nmi_in reaches pending on the third rising clock edge after it and irq_out on the fourth.
- R13: Read data is registered: rsp_rdata holds the addressed register's value from the edge that captures the read until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Asynchronous interrupt pin |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Request to the parent controller |

## Verification
The bench walks every mode through steady, rising and falling line patterns, and pending is cleared before each pattern. A design that swapped mode codes or confused level with edge would then report a wrong pending value. Directed tests go after the places where a wrong design fails without showing it: a clear while a level is still active must be followed by pending setting again, and an edge that lands in the same cycle as a clear must survive, where a clear-wins design would drop it. Other tests check that a write of 0 to pending does nothing, that a masked trigger still latches and appears once unmasked, and that the latency to irq_out is exactly four edges. The last group checks that an unmapped write touches nothing and that each layout decodes its own offsets.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] pend;
    logic [31:0] en;
  } reg_map_t;

  // Offsets per address layout; pending/enable swap in layout 2.
  function automatic reg_map_t layout_map(input int unsigned layout);
    reg_map_t m;
    m.ctrl = 32'h00;
    case (layout)
      1:       begin m.pend = 32'h04; m.en = 32'h34; end
      2:       begin m.pend = 32'h08; m.en = 32'h04; end
      default: begin m.pend = 32'h04; m.en = 32'h08; end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= RST_VAL;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= RST_VAL;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_trigger.sv
module nmi_trigger
  import nmi_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_s,
  input  trig_mode_e mode,
  output logic       trig,
  output logic       trig_is_edge
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE_VAL;
    else     prev_q <= line_s;
  end

  always_comb begin
    trig         = 1'b0;
    trig_is_edge = 1'b0;
    case (mode)
      TRIG_LVL_LO:    trig = ~line_s;
      TRIG_LVL_HI:    trig = line_s;
      TRIG_EDGE_FALL: begin trig = prev_q & ~line_s; trig_is_edge = 1'b1; end
      TRIG_EDGE_RISE: begin trig = ~prev_q & line_s; trig_is_edge = 1'b1; end
      default:        trig = 1'b0;
    endcase
  end

  // An edge of one polarity cannot repeat on the following cycle (R3, R5)
  p_edge_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (trig && trig_is_edge) |=> (!trig || !$stable(mode)));
endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
  import nmi_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32,
  parameter int unsigned LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              trig,
  input  logic              trig_is_edge,
  output trig_mode_e        mode,
  output logic              pend,
  output logic              en,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam reg_map_t          MAP    = layout_map(LAYOUT);
  localparam logic [ADDR_W-1:0] A_CTRL = MAP.ctrl[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_PEND = MAP.pend[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_EN   = MAP.en[ADDR_W-1:0];

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q, en_q;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_ctrl, hit_pend, hit_en, any_hit;
  logic              wr_ctrl, wr_en, clr;
  logic              pend_n;

  assign hit_ctrl = (req_addr == A_CTRL);
  assign hit_pend = (req_addr == A_PEND);
  assign hit_en   = (req_addr == A_EN);
  assign any_hit  = hit_ctrl | hit_pend | hit_en;

  assign wr_ctrl = req_valid & req_write & hit_ctrl;
  assign wr_en   = req_valid & req_write & hit_en;
  assign clr     = req_valid & req_write & hit_pend & req_wdata[0];

  // Edge triggers win over a clear; level triggers lose to it and
  // re-assert on the following cycle if the line is still active.
  always_comb begin
    if (trig_is_edge) pend_n = (pend_q & ~clr) | trig;
    else              pend_n = clr ? 1'b0 : (pend_q | trig);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_n;
      if (wr_ctrl) ctrl_q <= req_wdata;
      if (wr_en)   en_q   <= req_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (req_valid && !req_write) begin
      if (hit_ctrl)      rdata_q <= ctrl_q;
      else if (hit_pend) rdata_q <= {{(DATA_W-1){1'b0}}, pend_q};
      else if (hit_en)   rdata_q <= {{(DATA_W-1){1'b0}}, en_q};
      else               rdata_q <= '0;
    end
  end

  assign mode      = trig_mode_e'(ctrl_q[1:0]);
  assign pend      = pend_q;
  assign en        = en_q;
  assign rsp_rdata = rdata_q;

  // R7: a clear with no trigger leaves pending low
  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !trig) |=> !pend_q);
  // R7: pending is sticky without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr) |=> pend_q);
  // R8: an edge is never lost
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (trig && trig_is_edge) |=> pend_q);
  // R6: control only changes on its own write
  p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ctrl_q));
  // R11: unmapped reads return zero
  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !any_hit) |=> (rsp_rdata == '0));
  // R13: read data holds between reads
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));
endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl
  import nmi_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int unsigned LAYOUT      = 0,
  parameter int          SYNC_STAGES = 2,
  parameter logic        LINE_IDLE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_out
);
  logic       line_s;
  logic       trig, trig_is_edge;
  trig_mode_e mode;
  logic       pend, en;
  logic       irq_q;

  nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) sync_i (
    .clk(clk), .rst(rst), .d(nmi_in), .q(line_s)
  );

  nmi_trigger #(.IDLE_VAL(LINE_IDLE)) trig_i (
    .clk(clk), .rst(rst), .line_s(line_s), .mode(mode),
    .trig(trig), .trig_is_edge(trig_is_edge)
  );

  nmi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT(LAYOUT)) regs_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .trig(trig), .trig_is_edge(trig_is_edge),
    .mode(mode), .pend(pend), .en(en), .rsp_rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend & en;
  end

  assign irq_out = irq_q;

  // R9: a masked source never raises the request
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_out);
  // R9: pending and enabled raises the request one cycle later
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (pend && en) |=> irq_out);
endmodule

// File: tb/nmi_ctrl_tb_top.sv
module nmi_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b1;
  logic [2:0] vld = 3'b000;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd0, rd1, rd2;
  logic irq0, irq1, irq2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nmi_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(0)) dut_i (
    .clk(clk), .rst(rst), .nmi_in(line), .req_valid(vld[0]), .req_write(wr),
    .req_addr(addr), .req_wdata(wdata), .rsp_rdata(rd0), .irq_out(irq0));
  nmi_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(1)) dut1_i (
    .clk(clk), .rst(rst), .nmi_in(line), .req_valid(vld[1]), .req_write(wr),
    .req_addr(addr), .req_wdata(wdata), .rsp_rdata(rd1), .irq_out(irq1));
  nmi_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LAYOUT(2)) dut2_i (
    .clk(clk), .rst(rst), .nmi_in(line), .req_valid(vld[2]), .req_write(wr),
    .req_addr(addr), .req_wdata(wdata), .rsp_rdata(rd2), .irq_out(irq2));

  // Layout 0 offsets
  localparam logic [AW-1:0] O_CTRL = 8'h00;
  localparam logic [AW-1:0] O_PEND = 8'h04;
  localparam logic [AW-1:0] O_EN   = 8'h08;

  // Table rows: {mode[1:0], start line, end line, expected pending}
  localparam int NV = 12;
  localparam logic [4:0] TBL [0:NV-1] = '{
    5'b00_1_1_0, 5'b00_1_0_1, 5'b00_0_1_1,
    5'b01_1_0_1, 5'b01_0_1_0, 5'b01_1_1_0, 5'b01_0_0_0,
    5'b10_0_0_0, 5'b10_0_1_1,
    5'b11_0_1_1, 5'b11_1_0_0, 5'b11_1_1_0
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int unsigned d, input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    vld = 3'b000; vld[d] = 1'b1; wr = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    vld = 3'b000; wr = 1'b0;
  endtask

  task automatic bus_rd(input int unsigned d, input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    vld = 3'b000; vld[d] = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    vld = 3'b000;
    v = (d == 0) ? rd0 : (d == 1) ? rd1 : rd2;
  endtask

  task automatic set_line(input logic v);
    @(negedge clk);
    line = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    bus_rd(0, O_CTRL, v); chk("R1 ctrl", v, 0);
    bus_rd(0, O_PEND, v); chk("R1 pend", v, 0);
    bus_rd(0, O_EN, v);   chk("R1 en", v, 0);
    chk("R1 irq", {31'b0, irq0}, 0);

    // Table walk: R2 R3 R4 R5
    bus_wr(0, O_EN, 1);
    for (int i = 0; i < NV; i++) begin
      set_line(TBL[i][2]);
      bus_wr(0, O_CTRL, {30'b0, TBL[i][4:3]});
      idle(5);
      bus_wr(0, O_PEND, 1);
      set_line(TBL[i][1]);
      idle(6);
      bus_rd(0, O_PEND, v);
      chk($sformatf("R2/R3/R4/R5 mode=%0d row=%0d pend", TBL[i][4:3], i), v, {31'b0, TBL[i][0]});
      chk($sformatf("R9 row=%0d irq", i), {31'b0, irq0}, {31'b0, TBL[i][0]});
    end

    // R6 upper control bits read back
    set_line(1'b1);
    bus_wr(0, O_CTRL, 32'hA5C3_F00D);
    bus_rd(0, O_CTRL, v); chk("R6 ctrl readback", v, 32'hA5C3_F00D);
    bus_wr(0, O_CTRL, 32'h0000_0001);
    idle(4);
    bus_wr(0, O_PEND, 1);

    // R7 write 0 leaves pending set
    set_line(1'b0);
    idle(5);
    bus_wr(0, O_PEND, 32'hFFFF_FFFE);
    bus_rd(0, O_PEND, v); chk("R7 write0 no effect", v, 1);
    bus_wr(0, O_PEND, 1);
    bus_rd(0, O_PEND, v); chk("R7 w1c clears", v, 0);

    // R7 level re-sets after clear while active (mode 0, line low)
    bus_wr(0, O_CTRL, 0);
    idle(2);
    bus_wr(0, O_PEND, 1);
    idle(1);
    bus_rd(0, O_PEND, v); chk("R7 level re-set", v, 1);

    // R8 edge coinciding with clear
    set_line(1'b1);
    bus_wr(0, O_CTRL, 1);
    idle(5);
    bus_wr(0, O_PEND, 1);
    @(negedge clk); line = 1'b0;
    @(negedge clk);
    @(negedge clk);
    vld = 3'b001; wr = 1'b1; addr = O_PEND; wdata = 1;
    @(negedge clk);
    vld = 3'b000; wr = 1'b0;
    bus_rd(0, O_PEND, v); chk("R8 edge beats clear", v, 1);

    // R12 latency (falling edge, enabled)
    set_line(1'b1);
    idle(5);
    bus_wr(0, O_PEND, 1);
    idle(2);
    @(negedge clk); line = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R12 irq low after 3 edges", {31'b0, irq0}, 0);
    @(negedge clk);
    chk("R12 irq high after 4 edges", {31'b0, irq0}, 1);

    // R9 masked latch then unmask
    bus_wr(0, O_EN, 0);
    bus_wr(0, O_PEND, 1);
    set_line(1'b1);
    idle(2);
    set_line(1'b0);
    idle(6);
    chk("R9 masked irq low", {31'b0, irq0}, 0);
    bus_rd(0, O_PEND, v); chk("R9 latched while masked", v, 1);
    bus_wr(0, O_EN, 1);
    idle(1);
    chk("R9 irq after unmask", {31'b0, irq0}, 1);

    // R11 unmapped access
    bus_wr(0, O_CTRL, 32'h1234_5679);
    bus_wr(0, 8'h0C, 32'hFFFF_FFFF);
    bus_rd(0, 8'h0C, v);   chk("R11 unmapped read", v, 0);
    bus_rd(0, O_CTRL, v);  chk("R11 ctrl untouched", v, 32'h1234_5679);
    bus_rd(0, O_EN, v);    chk("R11 en untouched", v, 1);

    // R13 read data holds until next read
    idle(3);
    chk("R13 rdata held", rd0, 1);

    // R10 layouts
    bus_wr(1, 8'h34, 1);
    bus_rd(1, 8'h34, v);   chk("R10 layout1 enable at 0x34", v, 1);
    bus_rd(1, 8'h08, v);   chk("R10 layout1 0x08 unmapped", v, 0);
    bus_wr(2, 8'h04, 1);
    bus_rd(2, 8'h04, v);   chk("R10 layout2 enable at 0x04", v, 1);
    bus_wr(2, 8'h00, 32'h0000_0002);
    set_line(1'b1);
    idle(5);
    bus_rd(2, 8'h08, v);   chk("R10 layout2 pending at 0x08", v, 1);
    bus_rd(2, 8'h00, v);   chk("R10 layout2 ctrl at 0x00", v, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule